// File: doc/BRIEF.md
# Decimating SINC Count Filter

This block sits behind the period counter of a capacitive touch scan. Each scan period yields one charge-count sample. The filter adds up the samples of a programmable window of 1 to 32 consecutive periods. The sum is formed either as a plain first-order accumulation or through a second-order structure made of two cascaded integrators. A power-of-two divider then scales the result, and the block delivers a saturated 16-bit count together with a one-cycle done strobe.

A scan opens with a start pulse, which clears both integrators and the overflow flag and captures the configuration. Samples are then counted only when the sample strobe is high, so idle cycles between periods have no effect. After the last sample of the window, the scaled value appears on the result port and stays there until the next result. A sticky overflow flag reports whether that scan's result had to be clipped. A status output shows whether the filter is enabled.

Top module: `sinc_decim_filter`

## Requirements
- R1: A `scan_start` pulse while `cfg_enable` is high opens a scan. The result is produced after exactly N+1 accepted samples, where N is the value of `cfg_periods` (0 to 31). Cycles with `smp_valid` low do not count. `result_valid` is high for exactly one cycle: the cycle after the clock edge that accepts the last sample.
- R2: With `cfg_second_order` = 0, the value before scaling is the sum of the N+1 accepted counts.
- R3: With `cfg_second_order` = 1, let S_k be the running sum after the k-th accepted sample. The value before scaling is S_1 + S_2 + ... + S_(N+1).
- R4: Codes 0 to 7 on `cfg_cutoff` shift the value right by the code, dividing by 1 to 128. Codes 8 to 15 apply no division.
- R5: If the scaled value exceeds 0xFFFF, `result` is 0xFFFF and `ovf_flag` is 1 in the same cycle as `result_valid`. A scaled value of exactly 0xFFFF is not an overflow.
- R6: `ovf_flag` holds its value until the next accepted `scan_start`, which clears it. A scan that does not overflow leaves the flag at 0.
- R7: `cfg_periods`, `cfg_second_order` and `cfg_cutoff` are captured at `scan_start`. Changing them during a scan has no effect on that scan.
- R8: A sample is ignored if it arrives outside a scan or in the same cycle as `scan_start`. `result` holds its value between `result_valid` pulses.
- R9: A `scan_start` during a scan restarts it. All samples accepted before the restart are discarded.
- R10: While `cfg_enable` is low, `scan_start` is ignored and any scan in progress is dropped without a `result_valid`. `filt_active` follows `cfg_enable` one cycle later. `scan_busy` is high from the cycle after an accepted start until the edge that produces the result.
- R11: During reset and right after it, `result` is 0 and `result_valid`, `ovf_flag`, `scan_busy` and `filt_active` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Filter enable |
| cfg_periods | input | 5 | Window length minus one |
| cfg_second_order | input | 1 | 0 = first order, 1 = second order |
| cfg_cutoff | input | 4 | Divider code: right shift for codes 0-7, no division for codes 8-15 |
| scan_start | input | 1 | Start pulse for a scan |
| smp_valid | input | 1 | Per-period sample strobe |
| smp_count | input | 16 | Per-period charge count |
| result | output | 16 | Scaled, saturated filter result |
| result_valid | output | 1 | One-cycle pulse when a new result is loaded |
| ovf_flag | output | 1 | Result of the last scan was clipped |
| filt_active | output | 1 | Registered copy of the enable |
| scan_busy | output | 1 | A scan window is open |

## Verification
Four properties are checked on every cycle:
- the done strobe never lasts two cycles, and the result stays frozen between strobes;
- a rising overflow flag always coincides with a strobe carrying 0xFFFF;
- an accepted start clears the flag and opens the window, and the captured configuration stays still while the window is open;
- the period counter stays within the captured window, and a dropped enable closes the window.

Only the bench's scenarios can show that the arithmetic is right for both orders and for every cutoff code. The same holds for the exact 0xFFFF boundary, restarts in mid-window, aborts on disable, and samples that arrive in the start cycle.

// File: rtl/sinc_pkg.sv
package sinc_pkg;
  // Default widths of the filter datapath.
  localparam int unsigned CNT_W  = 16;  // sample and result width
  localparam int unsigned PER_W  = 5;   // window length field width
  localparam int unsigned CUT_W  = 4;   // cutoff code width
  localparam int unsigned STAGES = 2;   // integrator stages available
endpackage

// File: rtl/sinc_window_ctrl.sv
module sinc_window_ctrl #(
  parameter int unsigned PER_W = sinc_pkg::PER_W,
  parameter int unsigned CUT_W = sinc_pkg::CUT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             scan_start,
  input  logic             smp_valid,
  input  logic [PER_W-1:0] cfg_last,
  input  logic             cfg_order,
  input  logic [CUT_W-1:0] cfg_cutoff,
  output logic             start_go,
  output logic             acc_step,
  output logic             last_step,
  output logic             busy,
  output logic             active,
  output logic             order_q,
  output logic [CUT_W-1:0] cutoff_q
);
  logic             busy_q, busy_d;
  logic             act_q;
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [PER_W-1:0] last_q, last_d;
  logic             order_d;
  logic [CUT_W-1:0] cutoff_d;

  // Start, step and end-of-window decode.
  always_comb begin
    start_go  = enable && scan_start;
    acc_step  = enable && busy_q && smp_valid && !scan_start;
    last_step = acc_step && (cnt_q == last_q);
  end

  // Next-state logic.
  always_comb begin
    busy_d   = busy_q;
    cnt_d    = cnt_q;
    last_d   = last_q;
    order_d  = order_q;
    cutoff_d = cutoff_q;
    if (!enable) begin
      busy_d = 1'b0;
    end else if (start_go) begin
      busy_d   = 1'b1;
      cnt_d    = '0;
      last_d   = cfg_last;
      order_d  = cfg_order;
      cutoff_d = cfg_cutoff;
    end else if (last_step) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (acc_step) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      act_q    <= 1'b0;
      cnt_q    <= '0;
      last_q   <= '0;
      order_q  <= 1'b0;
      cutoff_q <= '0;
    end else begin
      busy_q   <= busy_d;
      act_q    <= enable;
      cnt_q    <= cnt_d;
      last_q   <= last_d;
      order_q  <= order_d;
      cutoff_q <= cutoff_d;
    end
  end

  assign busy   = busy_q;
  assign active = act_q;

  // R1: the period counter never runs past the captured window.
  assert_window_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= last_q));

  // R7: captured configuration is frozen while a window is open.
  assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && enable && !scan_start) |=>
      ($stable(last_q) && $stable(order_q) && $stable(cutoff_q)));
endmodule

// File: rtl/sinc_integrator.sv
module sinc_integrator #(
  parameter int unsigned CNT_W  = sinc_pkg::CNT_W,
  parameter int unsigned ACC_W  = 26,
  parameter int unsigned STAGES = sinc_pkg::STAGES,
  localparam int unsigned SEL_W = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [SEL_W-1:0] stage_sel,
  input  logic [CNT_W-1:0] smp,
  output logic [ACC_W-1:0] sum_next
);
  logic [STAGES-1:0][ACC_W-1:0] nxt_all;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [ACC_W-1:0] acc_q, acc_d, feed;
    logic             en;

    if (s == 0) begin : g_head
      assign feed = {{(ACC_W-CNT_W){1'b0}}, smp};
      assign en   = step;
    end else begin : g_tail
      // A later stage integrates the updated output of the stage before it.
      assign feed = nxt_all[s-1];
      assign en   = step && (SEL_W'(s) <= stage_sel);
    end

    always_comb begin
      if (clear)   acc_d = '0;
      else if (en) acc_d = acc_q + feed;
      else         acc_d = acc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_d;
    end

    assign nxt_all[s] = acc_d;
  end

  assign sum_next = nxt_all[stage_sel];
endmodule

// File: rtl/sinc_scaler.sv
module sinc_scaler #(
  parameter int unsigned CNT_W = sinc_pkg::CNT_W,
  parameter int unsigned ACC_W = 26,
  parameter int unsigned CUT_W = sinc_pkg::CUT_W,
  localparam int unsigned SH_W = CUT_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [ACC_W-1:0] sum,
  input  logic [CUT_W-1:0] cutoff,
  output logic [CNT_W-1:0] result,
  output logic             done,
  output logic             ovf
);
  logic [SH_W-1:0]  sh;
  logic [ACC_W-1:0] scaled;
  logic             sat;
  logic [CNT_W-1:0] res_q, res_d;
  logic             done_q, done_d, ovf_q, ovf_d;

  always_comb begin
    // Upper half of the code space means no division.
    sh     = cutoff[CUT_W-1] ? '0 : cutoff[SH_W-1:0];
    scaled = sum >> sh;
    sat    = |scaled[ACC_W-1:CNT_W];
  end

  always_comb begin
    res_d  = res_q;
    ovf_d  = ovf_q;
    done_d = load;
    if (clear) begin
      ovf_d = 1'b0;
    end else if (load) begin
      res_d = sat ? {CNT_W{1'b1}} : scaled[CNT_W-1:0];
      ovf_d = sat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      res_q  <= res_d;
      done_q <= done_d;
      ovf_q  <= ovf_d;
    end
  end

  assign result = res_q;
  assign done   = done_q;
  assign ovf    = ovf_q;

  // R1: the done strobe is a single-cycle pulse.
  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R8: the result only moves together with the strobe.
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(res_q));

  // R5: a new overflow always comes with a saturated result.
  assert_sat_on_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> (done_q && (res_q == {CNT_W{1'b1}})));
endmodule

// File: rtl/sinc_decim_filter.sv
module sinc_decim_filter #(
  parameter int unsigned CNT_W  = sinc_pkg::CNT_W,
  parameter int unsigned PER_W  = sinc_pkg::PER_W,
  parameter int unsigned CUT_W  = sinc_pkg::CUT_W,
  localparam int unsigned ACC_W = CNT_W + 2 * PER_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic [PER_W-1:0] cfg_periods,
  input  logic             cfg_second_order,
  input  logic [CUT_W-1:0] cfg_cutoff,
  input  logic             scan_start,
  input  logic             smp_valid,
  input  logic [CNT_W-1:0] smp_count,
  output logic [CNT_W-1:0] result,
  output logic             result_valid,
  output logic             ovf_flag,
  output logic             filt_active,
  output logic             scan_busy
);
  logic             start_go, acc_step, last_step, order_q;
  logic [CUT_W-1:0] cutoff_q;
  logic [ACC_W-1:0] sum_next;

  sinc_window_ctrl #(.PER_W(PER_W), .CUT_W(CUT_W)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (cfg_enable),
    .scan_start (scan_start),
    .smp_valid  (smp_valid),
    .cfg_last   (cfg_periods),
    .cfg_order  (cfg_second_order),
    .cfg_cutoff (cfg_cutoff),
    .start_go   (start_go),
    .acc_step   (acc_step),
    .last_step  (last_step),
    .busy       (scan_busy),
    .active     (filt_active),
    .order_q    (order_q),
    .cutoff_q   (cutoff_q)
  );

  sinc_integrator #(.CNT_W(CNT_W), .ACC_W(ACC_W), .STAGES(2)) i_integ (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_go),
    .step      (acc_step),
    .stage_sel (order_q),
    .smp       (smp_count),
    .sum_next  (sum_next)
  );

  sinc_scaler #(.CNT_W(CNT_W), .ACC_W(ACC_W), .CUT_W(CUT_W)) i_scale (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (start_go),
    .load   (last_step),
    .sum    (sum_next),
    .cutoff (cutoff_q),
    .result (result),
    .done   (result_valid),
    .ovf    (ovf_flag)
  );

  // R6: an accepted start clears the flag and opens the window.
  assert_start_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_start && cfg_enable) |=> (!ovf_flag && scan_busy && !result_valid));

  // R10: a disabled filter has no open window and produces no result.
  assert_disable_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (!scan_busy && !result_valid));
endmodule

// File: tb/test_sinc_decim_filter.sv
module test_sinc_decim_filter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_enable, cfg_second_order, scan_start, smp_valid;
  logic [4:0]  cfg_periods;
  logic [3:0]  cfg_cutoff;
  logic [15:0] smp_count, result;
  logic        result_valid, ovf_flag, filt_active, scan_busy;

  int checks = 0;
  int failures = 0;
  int unsigned vals [32];

  always #10 clk = ~clk;  // 50 MHz

  sinc_decim_filter i_sinc_decim_filter (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_periods(cfg_periods),
    .cfg_second_order(cfg_second_order), .cfg_cutoff(cfg_cutoff),
    .scan_start(scan_start), .smp_valid(smp_valid), .smp_count(smp_count),
    .result(result), .result_valid(result_valid), .ovf_flag(ovf_flag),
    .filt_active(filt_active), .scan_busy(scan_busy));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Expected value before saturation, computed from R2, R3 and R4.
  function automatic longint model(input int n, input bit ord, input int cut);
    longint s1 = 0, s2 = 0, v;
    for (int i = 0; i <= n; i++) begin
      s1 += vals[i];
      s2 += s1;
    end
    v = ord ? s2 : s1;
    return (cut >= 8) ? v : (v >> cut);
  endfunction

  function automatic int unsigned pick(input int mode, input int idx);
    case (mode)
      0:       return $urandom & 32'hFFFF;
      1:       return 32'hFFFF;
      2:       return $urandom % 256;
      default: return idx + 1;
    endcase
  endfunction

  task automatic fill(input int n, input int mode);
    for (int i = 0; i <= n; i++) vals[i] = pick(mode, i);
  endtask

  task automatic do_start(input int n, input bit ord, input int cut, input bit with_smp);
    cfg_periods = 5'(n); cfg_second_order = ord; cfg_cutoff = 4'(cut);
    scan_start = 1'b1;
    smp_valid = with_smp; smp_count = 16'hBEEF;
    @(negedge clk);
    scan_start = 1'b0; smp_valid = 1'b0;
    chk(scan_busy == 1'b1, "R10 busy after start", scan_busy, 1);
  endtask

  task automatic feed_check(input int n, input bit ord, input int cut, input bit gaps,
                            input bit scramble, input string tag);
    longint v = model(n, ord, cut);
    bit     eovf = (v > 65535);
    longint eres = eovf ? 65535 : v;
    if (scramble) begin  // R7: inputs move after capture
      cfg_periods = 5'($urandom); cfg_second_order = 1'($urandom); cfg_cutoff = 4'($urandom);
    end
    for (int i = 0; i <= n; i++) begin
      if (gaps) begin
        repeat ($urandom % 3) begin
          smp_valid = 1'b0; smp_count = 16'($urandom); @(negedge clk);
        end
      end
      smp_valid = 1'b1; smp_count = 16'(vals[i]);
      @(negedge clk);
      if (i < n) chk(result_valid == 1'b0, "R1 early strobe", result_valid, 0);
    end
    smp_valid = 1'b0;
    chk(result_valid == 1'b1, "R1 strobe", result_valid, 1);
    chk(result == 16'(eres), tag, result, eres);
    chk(ovf_flag == eovf, "R5 ovf", ovf_flag, eovf);
    chk(scan_busy == 1'b0, "R10 busy end", scan_busy, 0);
    @(negedge clk);
    chk(result_valid == 1'b0, "R1 pulse width", result_valid, 0);
    chk(result == 16'(eres), "R8 hold", result, eres);
    chk(ovf_flag == eovf, "R6 sticky", ovf_flag, eovf);
  endtask

  task automatic run_scan(input int n, input bit ord, input int cut, input int mode,
                          input bit gaps, input bit scramble, input string tag);
    fill(n, mode);
    do_start(n, ord, cut, 1'b0);
    feed_check(n, ord, cut, gaps, scramble, tag);
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'd7319));
    rst_n = 1'b0; cfg_enable = 1'b0; cfg_periods = '0; cfg_second_order = 1'b0;
    cfg_cutoff = '0; scan_start = 1'b0; smp_valid = 1'b0; smp_count = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(result == 16'd0, "R11 result", result, 0);
    chk(result_valid == 1'b0, "R11 valid", result_valid, 0);
    chk(ovf_flag == 1'b0, "R11 ovf", ovf_flag, 0);
    chk(scan_busy == 1'b0, "R11 busy", scan_busy, 0);
    chk(filt_active == 1'b0, "R11 active", filt_active, 0);

    cfg_enable = 1'b1;
    @(negedge clk);
    chk(filt_active == 1'b1, "R10 active follows enable", filt_active, 1);

    run_scan(0, 1'b0, 0, 2, 1'b0, 1'b0, "R2 single period");
    run_scan(31, 1'b0, 0, 1, 1'b0, 1'b0, "R5 first order saturate");

    // R10/R6: a start while disabled is ignored and the flag is kept
    cfg_enable = 1'b0;
    @(negedge clk);
    chk(filt_active == 1'b0, "R10 active low", filt_active, 0);
    scan_start = 1'b1; @(negedge clk); scan_start = 1'b0;
    chk(scan_busy == 1'b0, "R10 start ignored", scan_busy, 0);
    chk(ovf_flag == 1'b1, "R6 flag kept", ovf_flag, 1);
    cfg_enable = 1'b1;
    @(negedge clk);

    run_scan(31, 1'b0, 5, 1, 1'b0, 1'b0, "R5 exact 0xFFFF no overflow");
    run_scan(31, 1'b1, 7, 1, 1'b0, 1'b0, "R3 second order saturate");
    run_scan(3, 1'b1, 0, 3, 1'b0, 1'b0, "R3 second order ramp");
    run_scan(7, 1'b0, 9, 2, 1'b0, 1'b0, "R4 code 9 no division");
    run_scan(7, 1'b0, 8, 0, 1'b1, 1'b0, "R4 code 8 no division");
    run_scan(9, 1'b1, 3, 0, 1'b1, 1'b0, "R4 shift by 3");

    // R8: samples outside a scan leave everything untouched
    held = result;
    for (int i = 0; i < 5; i++) begin
      smp_valid = 1'b1; smp_count = 16'($urandom);
      @(negedge clk);
      chk(result_valid == 1'b0, "R8 idle sample strobe", result_valid, 0);
      chk(result == held, "R8 idle sample result", result, held);
    end
    smp_valid = 1'b0;

    // R8: a sample in the start cycle is not counted
    fill(2, 0);
    do_start(2, 1'b0, 0, 1'b1);
    feed_check(2, 1'b0, 0, 1'b0, 1'b0, "R8 start-cycle sample ignored");

    // R9: restart discards earlier samples
    do_start(4, 1'b0, 0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      smp_valid = 1'b1; smp_count = 16'hFFFF; @(negedge clk);
    end
    smp_valid = 1'b0;
    fill(4, 2);
    do_start(4, 1'b0, 0, 1'b0);
    feed_check(4, 1'b0, 0, 1'b0, 1'b0, "R9 restart");

    // R10: disable aborts a scan without a result
    do_start(5, 1'b1, 0, 1'b0);
    for (int i = 0; i < 2; i++) begin
      smp_valid = 1'b1; smp_count = 16'd100; @(negedge clk);
    end
    smp_valid = 1'b0; cfg_enable = 1'b0;
    @(negedge clk);
    chk(scan_busy == 1'b0, "R10 abort", scan_busy, 0);
    cfg_enable = 1'b1;
    for (int i = 0; i < 5; i++) begin
      smp_valid = 1'b1; smp_count = 16'd100; @(negedge clk);
      chk(result_valid == 1'b0, "R10 no result after abort", result_valid, 0);
    end
    smp_valid = 1'b0;
    @(negedge clk);

    // R7: configuration changes inside the window are ignored
    run_scan(4, 1'b1, 2, 0, 1'b0, 1'b1, "R7 frozen config");

    for (int k = 0; k < 40; k++) begin
      bit ord = 1'($urandom);
      run_scan($urandom % 32, ord, $urandom % 16, $urandom % 3, 1'b1, 1'($urandom),
               ord ? "R3 random" : "R2 random");
    end
    finish_run();
  end
endmodule